// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block produces every digital drive waveform an interline, progressive-scan CCD needs, all decoded from one clock. Two free-running counters track the clock position inside a line and the line inside a frame. From them the block derives the line and frame syncs, the four vertical transfer phases, the two sensor readout pulses, the two horizontal transfer phases, the reset-gate pulse, the substrate (electronic shutter) pulse, and the blanking and sample-hold strobes for the downstream correlated double sampler.

Line 0 of each frame is the readout line. On that line the photodiode charge moves into the vertical register, and no vertical transfer happens. Every other line starts with a burst of vertical shifts inside horizontal blanking. In progressive mode, each line gives one shift and both readout pulses fire together. In skip mode, each line gives three shifts, so one line in three reaches the output. Only the first readout pulse fires in skip mode, and the second vertical-phase pair is held low across the pulse and a guard interval after it. A shutter count N sets how many lines before readout the substrate pulses stop, which sets the exposure. The mode and N are sampled only at a frame boundary.

All positions, lengths and counts are parameters. Pixel and shift-step periods are powers of two, so the phase decode is a bit slice.

Top module: `ccd_tgen`

## Requirements
- R1: `hd_o` is high for the first HD_LEN clocks of every LINE_CLKS-clock line. `vd_o` is high for the whole of line 0 of every FRAME_LINES-line frame. Reset places the counters at line 0, position 0.
- R2: `blk_o` is high for the first BLK_LEN clocks of each line. While it is high, `h1_o`=1, `h2_o`=0, `rg_o`=1, and `shp_o`=`shd_o`=0.
- R3: Outside blanking, the pixel phase is the line position modulo PIX_DIV. `h1_o` is high for phases below PIX_DIV/2, `h2_o` is its complement, and `rg_o` is high for phases below RG_LEN.
- R4: Outside blanking, `shp_o` is high exactly at phase SHP_PH and `shd_o` exactly at phase SHD_PH.
- R5: Progressive mode (`mode_i`=0), line 0: `v2a_o` and `v2b_o` are high for RD_WIN clocks from position RD_START, while `v1_o` and `v3_o` stay low. `xsg1_o` and `xsg2_o` are both high for XSG_LEN clocks from RD_START+XSG_OFF.
- R6: Skip mode (`mode_i`=1), line 0: `xsg2_o` stays low and `xsg1_o` and `v2a_o` behave as in R5. `v2b_o` is low for XSG_LEN+HOLD_LEN clocks from RD_START+XSG_OFF and high for the rest of the readout window.
- R7: On lines 1 and up, vertical shifts start at VT_START. Each shift is four steps of STEP_CLKS clocks, with {v1,v2,v3} = 110, 010, 011, 001 and `v2a_o`=`v2b_o`=v2. There is one shift per line in progressive mode and SKIP_RATIO shifts in skip mode. At all other positions the phases are low.
- R8: With shutter count N, `sub_o` is high for SUB_LEN clocks from SUB_START on each line l where l ≥ 1 and l+N < FRAME_LINES. N=0 gives no pulse at all.
- R9: `mode_i` and `shut_lines_i` are sampled only on the last clock of a frame. A change during a frame leaves that frame unchanged. After reset the block runs in progressive mode with N=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | drive clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_i | input | 1 | 0 progressive, 1 skip mode |
| shut_lines_i | input | SHUT_W | shutter count N in lines |
| hd_o | output | 1 | line sync |
| vd_o | output | 1 | frame sync (readout line) |
| v1_o | output | 1 | vertical phase 1 |
| v2a_o | output | 1 | vertical phase 2, first half |
| v2b_o | output | 1 | vertical phase 2, second half |
| v3_o | output | 1 | vertical phase 3 |
| xsg1_o | output | 1 | readout pulse onto phase 2A |
| xsg2_o | output | 1 | readout pulse onto phase 2B |
| h1_o | output | 1 | horizontal phase 1 |
| h2_o | output | 1 | horizontal phase 2 |
| rg_o | output | 1 | reset gate |
| sub_o | output | 1 | substrate shutter pulse |
| blk_o | output | 1 | horizontal blanking |
| shp_o | output | 1 | precharge sample strobe |
| shd_o | output | 1 | data sample strobe |

## Verification
The bench switches mode and shutter count in the middle of a frame. A design that applied them at once would change the shift count or the pulse pattern too early in that frame. It runs N=0, N one below the frame length, and N above the frame length, and counts the substrate pulses per frame. An off-by-one in the exposure compare would add or drop a line, and a missing zero check would pulse on every line. On the readout line it follows `v2b_o` through the readout pulse and the guard interval in skip mode. A design that shared the progressive composition would keep `v2b_o` high or fire `xsg2_o` there. Every clock is also compared against the waveform rules, so a transfer table in the wrong order or a burst of the wrong length shows up at once.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;
   typedef enum logic {
      SCAN_ALL  = 1'b0,
      SCAN_SKIP = 1'b1
   } scan_mode_e;

   localparam int SHIFT_STEPS = 4;
endpackage

// File: rtl/ccdtg_timebase.sv
module ccdtg_timebase
   import ccdtg_pkg::*;
#(
   parameter int LINE_CLKS   = 1270,
   parameter int FRAME_LINES = 790,
   parameter int SHUT_W      = 10,
   parameter int PW          = 11,
   parameter int LW          = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  scan_mode_e        mode_i,
   input  logic [SHUT_W-1:0] shut_i,
   output logic [PW-1:0]     pcnt_o,
   output logic [LW-1:0]     lcnt_o,
   output scan_mode_e        mode_o,
   output logic [SHUT_W-1:0] shut_o
);
   logic eol, eof;

   assign eol = (pcnt_o == PW'(LINE_CLKS - 1));
   assign eof = eol && (lcnt_o == LW'(FRAME_LINES - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcnt_o <= '0;
         lcnt_o <= '0;
         mode_o <= SCAN_ALL;
         shut_o <= '0;
      end else begin
         pcnt_o <= eol ? '0 : pcnt_o + 1'b1;
         if (eol) lcnt_o <= eof ? '0 : lcnt_o + 1'b1;
         if (eof) begin
            mode_o <= mode_i;
            shut_o <= shut_i;
         end
      end
   end
endmodule

// File: rtl/ccdtg_horz.sv
module ccdtg_horz #(
   parameter int PW      = 11,
   parameter int PIX_DIV = 2,
   parameter int RG_LEN  = 1,
   parameter int BLK_LEN = 256,
   parameter int HD_LEN  = 40,
   parameter int SHP_PH  = 0,
   parameter int SHD_PH  = 1
) (
   input  logic [PW-1:0] pcnt_i,
   output logic          hd_o,
   output logic          blk_o,
   output logic          h1_o,
   output logic          h2_o,
   output logic          rg_o,
   output logic          shp_o,
   output logic          shd_o
);
   localparam int PB   = $clog2(PIX_DIV);
   localparam int HALF = PIX_DIV / 2;

   int   p, phi;
   logic h_act, rg_act;

   assign p     = int'(pcnt_i);
   assign phi   = int'(pcnt_i[PB-1:0]);
   assign h_act = (phi < HALF);

   generate
      if (RG_LEN == HALF) begin : g_rg_shared
         assign rg_act = h_act;
      end else begin : g_rg_own
         assign rg_act = (phi < RG_LEN);
      end
   endgenerate

   assign hd_o  = (p < HD_LEN);
   assign blk_o = (p < BLK_LEN);
   assign h1_o  = blk_o | h_act;
   assign h2_o  = ~blk_o & ~h_act;
   assign rg_o  = blk_o | rg_act;
   assign shp_o = ~blk_o & (phi == SHP_PH);
   assign shd_o = ~blk_o & (phi == SHD_PH);
endmodule

// File: rtl/ccdtg_vert.sv
module ccdtg_vert
   import ccdtg_pkg::*;
#(
   parameter int FRAME_LINES = 790,
   parameter int SKIP_RATIO  = 3,
   parameter int VT_START    = 10,
   parameter int STEP_CLKS   = 16,
   parameter int RD_START    = 20,
   parameter int RD_WIN      = 848,
   parameter int XSG_OFF     = 2,
   parameter int XSG_LEN     = 51,
   parameter int HOLD_LEN    = 100,
   parameter int SUB_START   = 210,
   parameter int SUB_LEN     = 40,
   parameter int PW          = 11,
   parameter int LW          = 10,
   parameter int SHUT_W      = 10
) (
   input  logic [PW-1:0]     pcnt_i,
   input  logic [LW-1:0]     lcnt_i,
   input  scan_mode_e        mode_i,
   input  logic [SHUT_W-1:0] shut_i,
   output logic              v1_o,
   output logic              v2a_o,
   output logic              v2b_o,
   output logic              v3_o,
   output logic              xsg1_o,
   output logic              xsg2_o,
   output logic              sub_o
);
   localparam int SB  = $clog2(STEP_CLKS);
   localparam int XS0 = RD_START + XSG_OFF;

   int   p, l, n, off, burst;
   logic skip, in_xsg, in_guard;
   logic [2:0] vpat;

   assign p     = int'(pcnt_i);
   assign l     = int'(lcnt_i);
   assign n     = int'(shut_i);
   assign skip  = (mode_i == SCAN_SKIP);
   assign off   = p - VT_START;
   assign burst = (skip ? SKIP_RATIO : 1) * SHIFT_STEPS * STEP_CLKS;
   assign in_xsg   = (p >= XS0) && (p < XS0 + XSG_LEN);
   assign in_guard = (p >= XS0) && (p < XS0 + XSG_LEN + HOLD_LEN);

   always_comb begin
      unique case ((off >>> SB) & 3)
         0:       vpat = 3'b110;
         1:       vpat = 3'b010;
         2:       vpat = 3'b011;
         default: vpat = 3'b001;
      endcase
   end

   always_comb begin
      v1_o = 1'b0; v2a_o = 1'b0; v2b_o = 1'b0; v3_o = 1'b0;
      xsg1_o = 1'b0; xsg2_o = 1'b0; sub_o = 1'b0;
      if (l == 0) begin
         if ((p >= RD_START) && (p < RD_START + RD_WIN)) begin
            v2a_o = 1'b1;
            v2b_o = skip ? ~in_guard : 1'b1;
         end
         xsg1_o = in_xsg;
         xsg2_o = in_xsg & ~skip;
      end else begin
         if ((off >= 0) && (off < burst)) begin
            v1_o  = vpat[2];
            v2a_o = vpat[1];
            v2b_o = vpat[1];
            v3_o  = vpat[0];
         end
         sub_o = (n != 0) && (l + n < FRAME_LINES) &&
                 (p >= SUB_START) && (p < SUB_START + SUB_LEN);
      end
   end
endmodule

// File: rtl/ccd_tgen.sv
module ccd_tgen
   import ccdtg_pkg::*;
#(
   parameter int LINE_CLKS   = 1270,
   parameter int FRAME_LINES = 790,
   parameter int SHUT_W      = 10,
   parameter int HD_LEN      = 40,
   parameter int BLK_LEN     = 256,
   parameter int PIX_DIV     = 2,
   parameter int RG_LEN      = 1,
   parameter int SHP_PH      = 0,
   parameter int SHD_PH      = 1,
   parameter int SKIP_RATIO  = 3,
   parameter int VT_START    = 10,
   parameter int STEP_CLKS   = 16,
   parameter int RD_START    = 20,
   parameter int RD_WIN      = 848,
   parameter int XSG_OFF     = 2,
   parameter int XSG_LEN     = 51,
   parameter int HOLD_LEN    = 100,
   parameter int SUB_START   = 210,
   parameter int SUB_LEN     = 40
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic [SHUT_W-1:0] shut_lines_i,
   output logic              hd_o,
   output logic              vd_o,
   output logic              v1_o,
   output logic              v2a_o,
   output logic              v2b_o,
   output logic              v3_o,
   output logic              xsg1_o,
   output logic              xsg2_o,
   output logic              h1_o,
   output logic              h2_o,
   output logic              rg_o,
   output logic              sub_o,
   output logic              blk_o,
   output logic              shp_o,
   output logic              shd_o
);
   localparam int PW        = $clog2(LINE_CLKS + 1);
   localparam int LW        = $clog2(FRAME_LINES + 1);
   localparam int VT_END    = VT_START + SKIP_RATIO * SHIFT_STEPS * STEP_CLKS;

   initial begin
      if ((1 << $clog2(PIX_DIV)) != PIX_DIV || PIX_DIV < 2)
         $error("PIX_DIV must be a power of two of at least 2");
      if ((1 << $clog2(STEP_CLKS)) != STEP_CLKS)
         $error("STEP_CLKS must be a power of two");
      if (RG_LEN < 1 || RG_LEN >= PIX_DIV)
         $error("RG_LEN must lie inside one pixel");
      if (SHP_PH == SHD_PH || SHP_PH >= PIX_DIV || SHD_PH >= PIX_DIV)
         $error("sample phases must differ and lie inside one pixel");
      if (HD_LEN > BLK_LEN || BLK_LEN >= LINE_CLKS)
         $error("line sync must sit inside blanking, blanking inside the line");
      if (VT_END > SUB_START || SUB_START + SUB_LEN > BLK_LEN)
         $error("shift burst and shutter pulse must fit blanking in that order");
      if (RD_START + RD_WIN > LINE_CLKS || XSG_OFF + XSG_LEN + HOLD_LEN > RD_WIN)
         $error("readout window does not fit");
      if (FRAME_LINES < 2)
         $error("FRAME_LINES too small");
   end

   logic [PW-1:0]     pcnt;
   logic [LW-1:0]     lcnt;
   scan_mode_e        mode_q;
   logic [SHUT_W-1:0] shut_q;

   ccdtg_timebase #(
      .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
      .SHUT_W(SHUT_W), .PW(PW), .LW(LW)
   ) timebase_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .mode_i(scan_mode_e'(mode_i)), .shut_i(shut_lines_i),
      .pcnt_o(pcnt), .lcnt_o(lcnt), .mode_o(mode_q), .shut_o(shut_q)
   );

   ccdtg_horz #(
      .PW(PW), .PIX_DIV(PIX_DIV), .RG_LEN(RG_LEN), .BLK_LEN(BLK_LEN),
      .HD_LEN(HD_LEN), .SHP_PH(SHP_PH), .SHD_PH(SHD_PH)
   ) horz_i (
      .pcnt_i(pcnt), .hd_o(hd_o), .blk_o(blk_o), .h1_o(h1_o),
      .h2_o(h2_o), .rg_o(rg_o), .shp_o(shp_o), .shd_o(shd_o)
   );

   ccdtg_vert #(
      .FRAME_LINES(FRAME_LINES), .SKIP_RATIO(SKIP_RATIO),
      .VT_START(VT_START), .STEP_CLKS(STEP_CLKS), .RD_START(RD_START),
      .RD_WIN(RD_WIN), .XSG_OFF(XSG_OFF), .XSG_LEN(XSG_LEN),
      .HOLD_LEN(HOLD_LEN), .SUB_START(SUB_START), .SUB_LEN(SUB_LEN),
      .PW(PW), .LW(LW), .SHUT_W(SHUT_W)
   ) vert_i (
      .pcnt_i(pcnt), .lcnt_i(lcnt), .mode_i(mode_q), .shut_i(shut_q),
      .v1_o(v1_o), .v2a_o(v2a_o), .v2b_o(v2b_o), .v3_o(v3_o),
      .xsg1_o(xsg1_o), .xsg2_o(xsg2_o), .sub_o(sub_o)
   );

   assign vd_o = (lcnt == '0);
endmodule

// File: rtl/ccd_tgen_chk.sv
module ccd_tgen_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic hd_o,
   input logic vd_o,
   input logic v1_o,
   input logic v2a_o,
   input logic v3_o,
   input logic xsg1_o,
   input logic xsg2_o,
   input logic h1_o,
   input logic h2_o,
   input logic rg_o,
   input logic sub_o,
   input logic blk_o,
   input logic shp_o,
   input logic shd_o
);
   AST_HD_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hd_o |-> blk_o); // R1
   AST_VD_AT_LINE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(vd_o) |-> $rose(hd_o)); // R1
   AST_BLANK_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_o |-> (h1_o && !h2_o && rg_o && !shp_o && !shd_o)); // R2
   AST_H_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !blk_o |-> (h1_o ^ h2_o)); // R3
   AST_SAMPLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(shp_o && shd_o)); // R4
   AST_XSG_ON_READ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xsg1_o |-> (vd_o && v2a_o && !v1_o && !v3_o)); // R5
   AST_XSG2_NEEDS_XSG1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xsg2_o |-> xsg1_o); // R6
   AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(v1_o && v3_o)); // R7
   AST_SUB_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sub_o |-> (!vd_o && blk_o && !v1_o && !v2a_o && !v3_o)); // R8
endmodule

bind ccd_tgen ccd_tgen_chk chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .hd_o(hd_o), .vd_o(vd_o),
   .v1_o(v1_o), .v2a_o(v2a_o), .v3_o(v3_o), .xsg1_o(xsg1_o),
   .xsg2_o(xsg2_o), .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o),
   .sub_o(sub_o), .blk_o(blk_o), .shp_o(shp_o), .shd_o(shd_o)
);

// File: tb/ccd_tgen_tb_top.sv
module ccd_tgen_tb_top;
   localparam int LC = 64, FL = 12, HDL = 4, BLK = 32, PIX = 4, RGL = 1;
   localparam int SHP = 1, SHD = 3, SKIPR = 3, VTS = 4, STEP = 2;
   localparam int RDS = 4, RDW = 48, XOFF = 2, XLEN = 6, HOLD = 10;
   localparam int SUBS = 28, SUBL = 4, SW = 4;

   logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
   logic [SW-1:0] shut = '0;
   logic hd, vd, v1, v2a, v2b, v3, xsg1, xsg2, h1, h2, rg, sub, blk, shp, shd;

   int checks = 0, fails = 0, sub_hi = 0, xs2_hi = 0;
   int mp = 0, ml = 0, mshut = 0;
   bit mmode = 1'b0, done = 1'b0;
   string note = "";

   always #5 clk = ~clk;

   ccd_tgen #(
      .LINE_CLKS(LC), .FRAME_LINES(FL), .SHUT_W(SW), .HD_LEN(HDL),
      .BLK_LEN(BLK), .PIX_DIV(PIX), .RG_LEN(RGL), .SHP_PH(SHP),
      .SHD_PH(SHD), .SKIP_RATIO(SKIPR), .VT_START(VTS), .STEP_CLKS(STEP),
      .RD_START(RDS), .RD_WIN(RDW), .XSG_OFF(XOFF), .XSG_LEN(XLEN),
      .HOLD_LEN(HOLD), .SUB_START(SUBS), .SUB_LEN(SUBL)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .shut_lines_i(shut),
      .hd_o(hd), .vd_o(vd), .v1_o(v1), .v2a_o(v2a), .v2b_o(v2b), .v3_o(v3),
      .xsg1_o(xsg1), .xsg2_o(xsg2), .h1_o(h1), .h2_o(h2), .rg_o(rg),
      .sub_o(sub), .blk_o(blk), .shp_o(shp), .shd_o(shd)
   );

   // position model from R1 and R9
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp <= 0; ml <= 0; mmode <= 1'b0; mshut <= 0;
      end else if (mp == LC - 1) begin
         mp <= 0;
         if (ml == FL - 1) begin
            ml <= 0; mmode <= mode; mshut <= int'(shut);
         end else ml <= ml + 1;
      end else mp <= mp + 1;
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s%s line %0d pos %0d: got %b expected %b",
                  tag, note, ml, mp, act, exp);
      end
   endtask

   task automatic compare_now();
      int ph = mp % PIX;
      bit eb = (mp < BLK);
      bit ea = (ph < PIX / 2);
      bit e1 = 0, e2a = 0, e2b = 0, e3 = 0, ex1 = 0, ex2 = 0, es = 0;
      int xs0 = RDS + XOFF;
      int off = mp - VTS;
      int len = (mmode ? SKIPR : 1) * 4 * STEP;
      if (ml == 0) begin
         if (mp >= RDS && mp < RDS + RDW) begin
            e2a = 1;
            e2b = mmode ? !(mp >= xs0 && mp < xs0 + XLEN + HOLD) : 1'b1;
         end
         ex1 = (mp >= xs0 && mp < xs0 + XLEN);
         ex2 = ex1 && !mmode;
      end else begin
         if (off >= 0 && off < len) begin
            case ((off / STEP) % 4)
               0: begin e1 = 1; e2a = 1; end
               1: e2a = 1;
               2: begin e2a = 1; e3 = 1; end
               default: e3 = 1;
            endcase
            e2b = e2a;
         end
         es = (mshut != 0) && (ml + mshut < FL) && (mp >= SUBS) && (mp < SUBS + SUBL);
      end
      chk(8'({hd, vd}), 8'({mp < HDL, ml == 0}), "R1");
      chk(8'({blk, h1, h2, rg}), 8'({eb, eb | ea, !eb & !ea, eb | (ph < RGL)}),
          eb ? "R2" : "R3");
      chk(8'({shp, shd}), 8'({!eb && ph == SHP, !eb && ph == SHD}), "R4");
      chk(8'({v1, v2a, v2b, v3, xsg1, xsg2}), 8'({e1, e2a, e2b, e3, ex1, ex2}),
          (ml == 0) ? (mmode ? "R6" : "R5") : "R7");
      chk(8'(sub), 8'(es), "R8");
      if (sub === 1'b1) sub_hi++;
      if (xsg2 === 1'b1) xs2_hi++;
   endtask

   task automatic run(input int n);
      repeat (n) begin
         @(negedge clk);
         compare_now();
      end
   endtask

   task automatic to_frame_start();
      do run(1); while (!(mp == 0 && ml == 0));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         compare_now();               // R1 reset state: line 0 position 0
      end
      rst_n = 1'b1;
      run(3);
   endtask

   task automatic t_progressive();
      mode = 1'b0; shut = '0;
      to_frame_start();
      sub_hi = 0; xs2_hi = 0;
      run(2 * LC * FL);
      chk(8'(sub_hi), 8'(0), "R8 N=0");
      chk(8'(xs2_hi / XLEN), 8'(2), "R5 xsg2 pulses");
   endtask

   task automatic t_skip();
      run(100);
      mode = 1'b1;
      note = " [R9 mode held]";
      to_frame_start();
      note = "";
      xs2_hi = 0;
      run(2 * LC * FL);
      chk(8'(xs2_hi), 8'(0), "R6 xsg2 silent");
   endtask

   task automatic t_shutter(input int n, input int pulses);
      run(37);
      shut = SW'(n);
      note = " [R9 count held]";
      to_frame_start();
      note = "";
      sub_hi = 0;
      run(LC * FL);
      chk(8'(sub_hi / SUBL), 8'(pulses), "R8 pulse count");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_progressive();
      t_shutter(3, FL - 1 - 3);
      t_skip();
      t_shutter(FL - 1, 0);
      t_shutter(15, 0);
      t_shutter(1, FL - 2);
      mode = 1'b0;
      t_shutter(0, 0);
      run(LC * FL);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule